// File: doc/BRIEF.md
# Four-Pin Configurable GPIO Bank with Edge Interrupts

This block drives and watches four general-purpose pads. A 32-bit control word holds one 8-bit control byte per pin. Each byte puts its pin in one of eight modes:

- One of four input modes: no interrupt, rising edge, falling edge or either edge.
- One of two fixed-level output modes: low or high.
- A monitor mode, in which the pad copies one bit of a 64-bit internal status vector chosen by a 6-bit index.
- A reserved encoding, which behaves as a quiet input.

Each pad input passes through a two-stage synchronizer. A previous-value register follows the synchronizer, and an edge is a difference between the synchronized value and that register. A qualifying edge sets a sticky per-pin interrupt flag. The flag stays set until a write-one-to-clear strobe bit for that pin arrives.

The decoded mode of each pin is an enumerated state. Its value follows only from the control byte:

| Byte pattern | State |
|---|---|
| `00xx_xxxx` with bits 5..4 = 00 | IN_NONE |
| `00xx_xxxx` with bits 5..4 = 01 | IN_RISE |
| `00xx_xxxx` with bits 5..4 = 10 | IN_FALL |
| `00xx_xxxx` with bits 5..4 = 11 | IN_BOTH |
| `01xx_xxxx` with bit 4 = 0 | OUT_LOW |
| `01xx_xxxx` with bit 4 = 1 | OUT_HIGH |
| `11ss_ssss` | MONITOR |
| `10xx_xxxx` | RESERVED |

A control write is the only transition. It moves a pin from any state to any other state on the clock edge where the write enable is high. Reset puts every pin in IN_NONE.

Top module: `gpio_bank`

## Requirements
- R1: The control byte for pin n occupies bits 8n+7..8n of the control word, so pin 3 uses bits 31..24 and pin 0 uses bits 7..0. `cfg_rdata` returns the last value written with `cfg_we`, and it is zero after reset.
- R2: Bits 7..6 = 00 select an input mode. In every input mode `pad_oe` and `pad_out` for that pin are 0.
- R3: In input mode with bits 5..4 = 01, a 0-to-1 transition of the synchronized pad sets the pin's flag.
- R4: In input mode with bits 5..4 = 10, a 1-to-0 transition of the synchronized pad sets the pin's flag.
- R5: In input mode with bits 5..4 = 11, a transition in either direction sets the pin's flag.
- R6: In input mode with bits 5..4 = 00, pad transitions never set the flag.
- R7: Bits 7..6 = 01 select fixed output. `pad_oe` is 1, `pad_out` equals control bit 4, and bits 5 and 3..0 have no effect.
- R8: Bits 7..6 = 11 select monitor mode. `pad_oe` is 1, and in the same cycle `pad_out` equals `status_in[idx]`, where idx is control bits 5..0.
- R9: Bits 7..6 = 10 are reserved. The pin then acts as an input with no interrupt: `pad_oe` = 0, `pad_out` = 0, and no flag is set.
- R10: A pad change applied before clock edge k shows in `irq_flag` right after edge k+2, and not earlier. This latency comes from two synchronizer stages plus the edge register.
- R11: A set flag stays set until an `irq_clr` bit of 1 arrives for that pin. When a qualifying edge and a clear fall in the same cycle, the flag ends up set.
- R12: Pad transitions never set a flag while the pin is in an output mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | New control word |
| cfg_rdata | output | 32 | Current control word |
| status_in | input | 64 | Internal status bits available to monitor mode |
| pad_in | input | 4 | Pad input levels, asynchronous |
| irq_clr | input | 4 | Per-pin write-one-to-clear strobe for the flags |
| irq_flag | output | 4 | Sticky per-pin interrupt flags |
| pad_oe | output | 4 | Per-pin pad output enable |
| pad_out | output | 4 | Per-pin pad output level |

## Verification
A wrong control register or mode decode shows on `pad_oe`, `pad_out` and `cfg_rdata` in the first cycle after the write. The bench therefore checks the output modes one cycle after each write. An error in the synchronizer or edge register shows as a flag arriving a cycle early or late, or on the wrong polarity. The edge tests therefore sample the flag both before and at the third edge after a pad change. A broken clear priority shows only in the cycle where a set and a clear coincide, so the bench lines one up on purpose.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int CTRL_W = 8;

    typedef enum logic [2:0] {
        PM_IN_NONE,
        PM_IN_RISE,
        PM_IN_FALL,
        PM_IN_BOTH,
        PM_OUT_LOW,
        PM_OUT_HIGH,
        PM_MONITOR,
        PM_RESERVED
    } pin_mode_e;

    function automatic pin_mode_e decode_mode(input logic [CTRL_W-1:0] b);
        pin_mode_e m;
        unique case (b[7:6])
            2'b00: begin
                unique case (b[5:4])
                    2'b00: m = PM_IN_NONE;
                    2'b01: m = PM_IN_RISE;
                    2'b10: m = PM_IN_FALL;
                    default: m = PM_IN_BOTH;
                endcase
            end
            2'b01: m = b[4] ? PM_OUT_HIGH : PM_OUT_LOW;
            2'b11: m = PM_MONITOR;
            default: m = PM_RESERVED;
        endcase
        return m;
    endfunction

    function automatic logic is_irq_mode(input pin_mode_e m);
        return (m == PM_IN_RISE) || (m == PM_IN_FALL) || (m == PM_IN_BOTH);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin.sv
module gpio_pin
    import gpio_bank_pkg::*;
#(
    parameter int STATUS_W = 64,
    localparam int SEL_W   = $clog2(STATUS_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CTRL_W-1:0]   ctrl,
    input  logic                pad_sync,
    input  logic [STATUS_W-1:0] status,
    input  logic                clr,
    output logic                flag,
    output logic                oe,
    output logic                out
);
    pin_mode_e        mode;
    logic             prev;
    logic             rise, fall, hit;
    logic [SEL_W-1:0] sel;

    assign mode = decode_mode(ctrl);
    assign sel  = ctrl[SEL_W-1:0];

    // Edge register: holds the synchronized level from one cycle earlier.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= pad_sync;
    end

    assign rise = pad_sync & ~prev;
    assign fall = ~pad_sync & prev;

    // Output and qualification process, one branch per mode state.
    always_comb begin
        hit = 1'b0;
        oe  = 1'b0;
        out = 1'b0;
        unique case (mode)
            PM_IN_NONE:  hit = 1'b0;
            PM_IN_RISE:  hit = rise;
            PM_IN_FALL:  hit = fall;
            PM_IN_BOTH:  hit = rise | fall;
            PM_OUT_LOW:  oe  = 1'b1;
            PM_OUT_HIGH: begin oe = 1'b1; out = 1'b1; end
            PM_MONITOR:  begin oe = 1'b1; out = status[sel]; end
            PM_RESERVED: hit = 1'b0;
            default:     hit = 1'b0;
        endcase
    end

    // Sticky flag: a set beats a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R11: a qualifying edge always leaves the flag set, even with a clear.
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    // R11: the flag holds until a clear arrives.
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R12 and R6: the flag rises only while an interrupt input mode is active.
    a_r12_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(is_irq_mode(mode)));

    // R2 and R9: every pad driver is off while the control byte has bit 6 = 0.
    a_r2_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[6] |-> (!oe && !out));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int PINS     = 4,
    parameter int STATUS_W = 64,
    parameter int SYNC_STG = 2,
    localparam int CFG_W   = PINS * CTRL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic [CFG_W-1:0]    cfg_rdata,
    input  logic [STATUS_W-1:0] status_in,
    input  logic [PINS-1:0]     pad_in,
    input  logic [PINS-1:0]     irq_clr,
    output logic [PINS-1:0]     irq_flag,
    output logic [PINS-1:0]     pad_oe,
    output logic [PINS-1:0]     pad_out
);
    localparam int SEL_W = $clog2(STATUS_W);

    logic [CFG_W-1:0] cfg_q;

    // State register for all pin modes: a write is the only transition.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wdata;
    end

    assign cfg_rdata = cfg_q;

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        logic pad_s;

        gpio_sync #(.STAGES(SYNC_STG)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (pad_in[p]),
            .q_sync  (pad_s)
        );

        gpio_pin #(.STATUS_W(STATUS_W)) u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl     (cfg_q[p*CTRL_W +: CTRL_W]),
            .pad_sync (pad_s),
            .status   (status_in),
            .clr      (irq_clr[p]),
            .flag     (irq_flag[p]),
            .oe       (pad_oe[p]),
            .out      (pad_out[p])
        );

        // R8: in monitor mode the pad copies the indexed status bit.
        a_r8_monitor_follow: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_rdata[p*CTRL_W+7 -: 2] == 2'b11) |->
                (pad_oe[p] && pad_out[p] == status_in[cfg_rdata[p*CTRL_W +: SEL_W]]));

        // R7: in fixed output mode the pad level is control bit 4.
        a_r7_fixed_level: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_rdata[p*CTRL_W+7 -: 2] == 2'b01) |->
                (pad_oe[p] && pad_out[p] == cfg_rdata[p*CTRL_W+4]));
    end

    // R1: the control word reads back as zero after a reset edge.
    a_r1_reset_cfg: assert property (@(posedge clk)
        !rst_n |=> (cfg_rdata == '0));

    // R1: the control word changes only when it is written.
    a_r1_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));
endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [63:0] status_in;
    logic [3:0]  pad_in;
    logic [3:0]  irq_clr;
    logic [3:0]  irq_flag;
    logic [3:0]  pad_oe;
    logic [3:0]  pad_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gpio_bank dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .status_in (status_in),
        .pad_in    (pad_in),
        .irq_clr   (irq_clr),
        .irq_flag  (irq_flag),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out)
    );

    // Output-mode vectors: control word, status, expected oe, expected out.
    localparam int NV = 7;
    localparam logic [31:0] V_CFG [NV] = '{
        32'h0000_0000, 32'h5050_4050, 32'hE0C5_FFC0, 32'hE0C5_FFC0,
        32'h80BF_A080, 32'hC010_5090, 32'h6060_6060};
    localparam logic [63:0] V_ST [NV] = '{
        64'h0, 64'h0, 64'h8000_0001_0000_0020, 64'h1,
        64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF};
    localparam logic [3:0] V_OE [NV] = '{4'h0, 4'hF, 4'hF, 4'hF, 4'h0, 4'hA, 4'hF};
    localparam logic [3:0] V_OUT [NV] = '{4'h0, 4'hD, 4'hE, 4'h1, 4'h0, 4'hA, 4'h0};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        irq_clr = 4'hF;
        @(negedge clk);
        irq_clr = 4'h0;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; status_in = '0;
        pad_in = '0; irq_clr = '0;
        settle(3);
        rst_n = 1'b1;
        settle(1);
        chk("R1 reset cfg", cfg_rdata, 32'h0);
        chk("R2 reset oe", pad_oe, 4'h0);
        chk("R11 reset flags", irq_flag, 4'h0);

        // Vector table: output modes, monitor, reserved, readback.
        for (int i = 0; i < NV; i++) begin
            status_in = V_ST[i];
            wr(V_CFG[i]);
            chk("R1 readback", cfg_rdata, V_CFG[i]);
            chk("R7/R8/R9 oe", pad_oe, V_OE[i]);
            chk("R7/R8/R9 out", pad_out, V_OUT[i]);
        end

        // R8: monitor follows status in the same cycle, without a write.
        wr(32'hE0C5_FFC0);
        status_in = 64'h0000_0000_0000_0021;
        #1;
        chk("R8 same-cycle follow", pad_out, 4'h5);

        // Edge modes: pin0 rise, pin1 fall, pin2 both, pin3 none.
        wr(32'h0030_2010);
        settle(4);
        clear_all();
        pad_in = 4'hF;               // driven at a negedge before edge k
        settle(2);                   // edges k and k+1 have passed
        chk("R10 no early flag", irq_flag, 4'h0);
        settle(1);                   // edge k+2 has passed
        chk("R3 R5 R6 rise", irq_flag, 4'h5);
        settle(3);
        chk("R11 sticky", irq_flag, 4'h5);
        clear_all();
        chk("R11 cleared", irq_flag, 4'h0);
        pad_in = 4'h0;
        settle(4);
        chk("R4 R5 R6 fall", irq_flag, 4'h6);
        clear_all();

        // R11: a clear in the same cycle as a set leaves the flag set.
        pad_in = 4'h1;               // rise on pin0 lands at edge k+2
        settle(2);
        irq_clr = 4'h1;              // clear held across edge k+2
        @(negedge clk);
        irq_clr = 4'h0;
        chk("R11 set wins", irq_flag[0], 1'b1);
        clear_all();
        pad_in = 4'h0;
        settle(4);
        clear_all();

        // R9: reserved mode ignores edges.
        wr(32'h8080_8080);
        pad_in = 4'hF; settle(4);
        pad_in = 4'h0; settle(4);
        chk("R9 reserved no flag", irq_flag, 4'h0);
        chk("R9 reserved oe", pad_oe, 4'h0);

        // R12: output modes ignore pad edges.
        wr(32'hC040_5040);
        pad_in = 4'hF; settle(4);
        pad_in = 4'h0; settle(4);
        chk("R12 output no flag", irq_flag, 4'h0);

        // R1: byte lanes are independent; only pin3 set high.
        wr(32'h5000_0000);
        chk("R1 lane pin3 oe", pad_oe, 4'h8);
        chk("R1 lane pin3 out", pad_out, 4'h8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule